// File: doc/BRIEF.md
# Multi-bit-per-cycle SAR sequencer

This block is the digital controller of a 10-bit successive-approximation converter with a capacitor main array. After a start request it runs eight conversion cycles. The first two cycles are coarse. Each one reads six coarse comparator outputs, places the array voltage in one of seven mirrored regions, and switches up to two capacitors at once. The remaining six cycles are binary. Each one reads a single fine comparator and resolves one bit.

During each coarse cycle a small level-shift capacitor lifts the array voltage. This lets the middle threshold be the common-mode level. The shift is removed as the following cycle begins. Capacitors C1 to C5 have split halves that move in opposite directions, so the common mode stays fixed. C6 to C9 are switched on one side only. The per-cycle decisions are summed with overlapping weights into a 10-bit code, and `done` is pulsed when the code is ready.

A comparator result is taken only on a rising edge of `cmp_valid`. In cycle 2, an out-of-tolerance coarse pattern is remapped to the code that the tolerance band expects.

Top module: `sar_seq_top`

## Requirements
- R1: While `rst` is high, and after it, every split half of type a reads 1 and every half of type b reads 0 on both sides. All `mono_p`/`mono_n` bits read 1, `code` reads 0, `done` reads 0, and the sequencer is idle. In all switch outputs, 1 means tied to the reference and 0 means tied to ground.
- R2: A `start` seen while idle returns all switches to their R1 values on the next clock and begins cycle 1. It also applies the first shift on split capacitor index 2 (p half b = 1, n half a = 0). A `start` while a conversion runs has no effect.
- R3: A decision is taken only in the clock where `cmp_valid` is 1 and was 0 in the previous clock. Holding `cmp_valid` high yields one decision, and edges while idle change nothing.
- R4: In cycles 1 and 2, the number of ones n among `coarse_in[5:0]` gives the region, in any bit order. n=0 or 6 is region A, 1 or 5 is B, 2 or 4 is C, and 3 is D. The voltage counts as above the midpoint when n >= 4.
- R5: Cycle k (k = 1, 2) owns split capacitors 2k-2 (major) and 2k-1 (minor). Region A moves both, B moves the major only, C moves the minor only, and D moves neither. A move when above sets p half a = 0 and n half b = 1. A move when below sets p half b = 1 and n half a = 0.
- R6: The cycle 1 decision also releases the shift on index 2 (restores its R1 values) and applies a shift on index 4 (p half b = 1, n half a = 0). The cycle 2 decision releases the shift on index 4.
- R7: In cycle 2 only, region B (n = 1 or 5) is treated as region C with the same polarity. This applies to switching and to the code.
- R8: Cycle 3 moves split capacitor 4 per R5, using `fine_in` as the above flag. Cycles 4 to 7 ground `mono_p[c-4]` if `fine_in` is 1, else `mono_n[c-4]`. Cycle 8 switches nothing.
- R9: The code starts at 512. Cycles 1 and 2 add the sum of the weights of the capacitors moved, with a plus sign when above and a minus sign otherwise; capacitor i has weight 256 >> i. Cycles 3 to 7 add plus or minus 16, 8, 4, 2 and 1 by `fine_in`. Cycle 8 subtracts 1 when `fine_in` is 0. `code` takes this value and `done` is 1 for exactly one clock, both just after the cycle 8 decision clock.
- R10: For every split capacitor, exactly two of its four halves (p a, p b, n a, n b) are tied to the reference at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | conversion request |
| cmp_valid | input | 1 | comparator result strobe, rising edge used |
| coarse_in | input | 6 | coarse comparator outputs |
| fine_in | input | 1 | fine comparator output, 1 = positive side higher |
| split_p_a | output | 5 | positive array, half a of split capacitors C1..C5 |
| split_p_b | output | 5 | positive array, half b of split capacitors C1..C5 |
| split_n_a | output | 5 | negative array, half a of split capacitors C1..C5 |
| split_n_b | output | 5 | negative array, half b of split capacitors C1..C5 |
| mono_p | output | 4 | positive array, capacitors C6..C9 |
| mono_n | output | 4 | negative array, capacitors C6..C9 |
| code | output | 10 | converted code |
| done | output | 1 | one-clock pulse when `code` is updated |

## Verification
Every result is registered once. Switch changes for a decision appear right after the clock edge where the first high `cmp_valid` sample is seen. The shift set by `start` appears one clock after `start`. `code` and `done` appear one clock after the cycle 8 strobe. The bench drives inputs on falling edges, and a behavioural model updates on each rising edge from the same inputs. Every output is compared with the model on the following falling edge, so each check samples exactly one register delay after its stimulus. Targeted scenarios cover non-monotonic coarse patterns, the cycle 2 remap, held strobes, idle strobes and start requests during a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    localparam int OUT_W        = 10;
    localparam int N_COARSE     = 6;
    localparam int N_SPLIT      = 5;
    localparam int N_MONO       = 4;
    localparam int N_COARSE_CYC = 2;
    localparam int N_CYC        = N_COARSE_CYC + 1 + N_MONO + 1;
    localparam int CYC_W        = $clog2(N_CYC + 1);
    localparam int SIDX_W       = $clog2(N_SPLIT);
    localparam int MIDX_W       = $clog2(N_MONO);
    localparam int ACC_W        = OUT_W + 2;
    localparam int MID_CODE     = 1 << (OUT_W - 1);
    localparam int CNT_W        = $clog2(N_COARSE + 1);
    localparam int HALF_CNT     = N_COARSE / 2;
    localparam logic [SIDX_W-1:0] SHIFT1_IDX = SIDX_W'(2);
    localparam logic [SIDX_W-1:0] SHIFT2_IDX = SIDX_W'(4);

    typedef enum logic [1:0] {RG_D = 2'd0, RG_C = 2'd1, RG_B = 2'd2, RG_A = 2'd3} region_e;

    typedef struct packed {
        logic    above;
        region_e region;
    } coarse_dec_t;

    typedef struct packed {
        logic [N_SPLIT-1:0] pa;
        logic [N_SPLIT-1:0] pb;
        logic [N_SPLIT-1:0] na;
        logic [N_SPLIT-1:0] nb;
    } split_sw_t;

    typedef struct packed {
        logic [N_MONO-1:0] mp;
        logic [N_MONO-1:0] mn;
    } mono_sw_t;

    function automatic int cap_weight(input int k);
        return 1 << (OUT_W - 2 - k);
    endfunction

    function automatic logic [CNT_W-1:0] count_ones(input logic [N_COARSE-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < N_COARSE; i++) n = n + CNT_W'(v[i]);
        return n;
    endfunction

    function automatic split_sw_t split_move(input split_sw_t s, input logic [SIDX_W-1:0] k,
                                             input logic above);
        split_sw_t r;
        r = s;
        if (above) begin
            r.pa[k] = 1'b0;
            r.nb[k] = 1'b1;
        end else begin
            r.pb[k] = 1'b1;
            r.na[k] = 1'b0;
        end
        return r;
    endfunction

    function automatic split_sw_t split_release(input split_sw_t s, input logic [SIDX_W-1:0] k);
        split_sw_t r;
        r = s;
        r.pb[k] = 1'b0;
        r.na[k] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/sar_coarse_decode.sv
module sar_coarse_decode
    import sar_seq_pkg::*;
(
    input  logic [N_COARSE-1:0] coarse,
    input  logic                correct_en,
    output coarse_dec_t         dec
);
    logic [CNT_W-1:0] ones;
    logic [CNT_W-1:0] mag;

    always_comb begin
        ones = count_ones(coarse);
        if (ones > CNT_W'(HALF_CNT)) begin
            dec.above = 1'b1;
            mag       = ones - CNT_W'(HALF_CNT);
        end else begin
            dec.above = 1'b0;
            mag       = CNT_W'(HALF_CNT) - ones;
        end
        if (correct_en && mag == CNT_W'(2)) mag = CNT_W'(1);
        dec.region = region_e'(mag[1:0]);
    end
endmodule

// File: rtl/sar_switch_bank.sv
module sar_switch_bank
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             apply,
    input  logic [CYC_W-1:0] cyc,
    input  coarse_dec_t      dec,
    input  logic             fine,
    output split_sw_t        sw_s,
    output mono_sw_t         sw_m
);
    split_sw_t s_q, s_nx, s_idle;
    mono_sw_t  m_q, m_nx;
    logic [SIDX_W-1:0] major;
    logic [MIDX_W-1:0] midx;

    always_comb begin
        s_idle.pa = '1;
        s_idle.pb = '0;
        s_idle.na = '1;
        s_idle.nb = '0;
        s_nx  = s_q;
        m_nx  = m_q;
        major = (cyc == CYC_W'(1)) ? SIDX_W'(0) : SIDX_W'(2);
        midx  = MIDX_W'(cyc - CYC_W'(N_COARSE_CYC + 2));
        if (load) begin
            s_nx = split_move(s_idle, SHIFT1_IDX, 1'b0);
            m_nx = '1;
        end else if (apply) begin
            if (cyc <= CYC_W'(N_COARSE_CYC)) begin
                if (cyc == CYC_W'(1)) begin
                    s_nx = split_release(s_nx, SHIFT1_IDX);
                    s_nx = split_move(s_nx, SHIFT2_IDX, 1'b0);
                end else begin
                    s_nx = split_release(s_nx, SHIFT2_IDX);
                end
                if (dec.region == RG_A || dec.region == RG_B)
                    s_nx = split_move(s_nx, major, dec.above);
                if (dec.region == RG_A || dec.region == RG_C)
                    s_nx = split_move(s_nx, major + SIDX_W'(1), dec.above);
            end else if (cyc == CYC_W'(N_COARSE_CYC + 1)) begin
                s_nx = split_move(s_nx, SIDX_W'(N_SPLIT - 1), fine);
            end else if (cyc < CYC_W'(N_CYC)) begin
                if (fine) m_nx.mp[midx] = 1'b0;
                else      m_nx.mn[midx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= s_idle;
            m_q <= '1;
        end else begin
            s_q <= s_nx;
            m_q <= m_nx;
        end
    end

    assign sw_s = s_q;
    assign sw_m = m_q;

    for (genvar k = 0; k < N_SPLIT; k++) begin : g_cm
        assert_split_cm_R10: assert property (@(posedge clk) disable iff (rst)
            $countones({s_q.pa[k], s_q.pb[k], s_q.na[k], s_q.nb[k]}) == 2);
    end

    assert_mono_fall_only_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> (((m_q.mp & ~$past(m_q.mp)) == '0) && ((m_q.mn & ~$past(m_q.mn)) == '0)));
endmodule

// File: rtl/sar_code_accum.sv
module sar_code_accum
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             apply,
    input  logic [CYC_W-1:0] cyc,
    input  coarse_dec_t      dec,
    input  logic             fine,
    output logic [OUT_W-1:0] code,
    output logic             done
);
    logic signed [ACC_W-1:0] acc_q, acc_nx;
    int delta, mag, major;

    always_comb begin
        delta = 0;
        mag   = 0;
        major = (cyc == CYC_W'(1)) ? 0 : 2;
        if (cyc <= CYC_W'(N_COARSE_CYC)) begin
            case (dec.region)
                RG_A:    mag = cap_weight(major) + cap_weight(major + 1);
                RG_B:    mag = cap_weight(major);
                RG_C:    mag = cap_weight(major + 1);
                default: mag = 0;
            endcase
            delta = dec.above ? mag : -mag;
        end else if (cyc < CYC_W'(N_CYC)) begin
            mag   = cap_weight(int'(cyc) + 1);
            delta = fine ? mag : -mag;
        end else begin
            delta = fine ? 0 : -1;
        end
        acc_nx = acc_q + ACC_W'(delta);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            code  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                acc_q <= ACC_W'(MID_CODE);
            end else if (apply) begin
                acc_q <= acc_nx;
                if (cyc == CYC_W'(N_CYC)) begin
                    code <= acc_nx[OUT_W-1:0];
                    done <= 1'b1;
                end
            end
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cmp_valid,
    input  logic [N_COARSE-1:0] coarse_in,
    input  logic                fine_in,
    output logic [N_SPLIT-1:0]  split_p_a,
    output logic [N_SPLIT-1:0]  split_p_b,
    output logic [N_SPLIT-1:0]  split_n_a,
    output logic [N_SPLIT-1:0]  split_n_b,
    output logic [N_MONO-1:0]   mono_p,
    output logic [N_MONO-1:0]   mono_n,
    output logic [OUT_W-1:0]    code,
    output logic                done
);
    typedef enum logic {ST_IDLE, ST_CONV} state_e;

    state_e           st_q;
    logic [CYC_W-1:0] cyc_q;
    logic             valid_q;
    logic             strobe_rise, load, apply;
    coarse_dec_t      dec;
    split_sw_t        sw_s;
    mono_sw_t         sw_m;

    assign strobe_rise = cmp_valid & ~valid_q;
    assign load        = (st_q == ST_IDLE) & start;
    assign apply       = (st_q == ST_CONV) & strobe_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cyc_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= cmp_valid;
            if (load) begin
                st_q  <= ST_CONV;
                cyc_q <= CYC_W'(1);
            end else if (apply) begin
                if (cyc_q == CYC_W'(N_CYC)) begin
                    st_q  <= ST_IDLE;
                    cyc_q <= '0;
                end else begin
                    cyc_q <= cyc_q + CYC_W'(1);
                end
            end
        end
    end

    sar_coarse_decode u_dec (
        .coarse     (coarse_in),
        .correct_en (cyc_q == CYC_W'(2)),
        .dec        (dec)
    );

    sar_switch_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .apply (apply),
        .cyc   (cyc_q),
        .dec   (dec),
        .fine  (fine_in),
        .sw_s  (sw_s),
        .sw_m  (sw_m)
    );

    sar_code_accum u_acc (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .apply (apply),
        .cyc   (cyc_q),
        .dec   (dec),
        .fine  (fine_in),
        .code  (code),
        .done  (done)
    );

    assign split_p_a = sw_s.pa;
    assign split_p_b = sw_s.pb;
    assign split_n_a = sw_s.na;
    assign split_n_b = sw_s.nb;
    assign mono_p    = sw_m.mp;
    assign mono_n    = sw_m.mn;

    assert_no_b_in_cycle2_R7: assert property (@(posedge clk) disable iff (rst)
        (apply && cyc_q == CYC_W'(2)) |-> dec.region != RG_B);

    assert_busy_ignores_start_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV && !apply) |=> (st_q == ST_CONV && $stable(cyc_q)));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !start) |=> ($stable(split_p_a) && $stable(split_n_b) && $stable(mono_p)
                                         && $stable(mono_n) && $stable(code)));
endmodule

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       cmp_valid = 1'b0;
    logic [5:0] coarse_in = '0;
    logic       fine_in = 1'b0;
    logic [4:0] split_p_a, split_p_b, split_n_a, split_n_b;
    logic [3:0] mono_p, mono_n;
    logic [9:0] code;
    logic       done;

    int total = 0;
    int bad = 0;
    int wd = 0;
    int dones = 0;
    bit started = 0;

    // behavioural expectation
    int spa[5], spb[5], sna[5], snb[5], mp[4], mn[4];
    int m_code, m_done, m_busy, m_cyc, m_prev, m_acc;

    always #4 clk = ~clk;

    sar_seq_top dut_i (
        .clk(clk), .rst(rst), .start(start), .cmp_valid(cmp_valid),
        .coarse_in(coarse_in), .fine_in(fine_in),
        .split_p_a(split_p_a), .split_p_b(split_p_b),
        .split_n_a(split_n_a), .split_n_b(split_n_b),
        .mono_p(mono_p), .mono_n(mono_n), .code(code), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic mv(input int k, input int up);
        if (up != 0) begin spa[k] = 0; snb[k] = 1; end
        else begin spb[k] = 1; sna[k] = 0; end
    endtask

    task automatic m_idle();
        for (int k = 0; k < 5; k++) begin spa[k] = 1; spb[k] = 0; sna[k] = 1; snb[k] = 0; end
        for (int k = 0; k < 4; k++) begin mp[k] = 1; mn[k] = 1; end
    endtask

    always @(posedge clk) begin
        started = 1;
        wd++;
        if (wd > 50000) begin
            bad++; total++;
            $display("FAIL watchdog R9 act=%0d exp=%0d", wd, 50000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst) begin
            m_idle();
            m_code = 0; m_done = 0; m_busy = 0; m_cyc = 0; m_prev = 0; m_acc = 0;
        end else begin
            int rise, n, d, up, mag, hi, amt;
            rise = (cmp_valid && m_prev == 0) ? 1 : 0;
            m_prev = cmp_valid ? 1 : 0;
            m_done = 0;
            if (m_busy == 0 && start) begin
                m_idle();
                mv(2, 0);
                m_acc = 512; m_busy = 1; m_cyc = 1;
            end else if (m_busy != 0 && rise != 0) begin
                if (m_cyc <= 2) begin
                    n = 0;
                    for (int i = 0; i < 6; i++) n += coarse_in[i];
                    d = n - 3;
                    up = (d > 0) ? 1 : 0;
                    mag = (d < 0) ? -d : d;
                    if (m_cyc == 2 && mag == 2) mag = 1;
                    hi = (m_cyc == 1) ? 0 : 2;
                    if (m_cyc == 1) begin spb[2] = 0; sna[2] = 1; mv(4, 0); end
                    else begin spb[4] = 0; sna[4] = 1; end
                    amt = 0;
                    if (mag == 3 || mag == 2) begin mv(hi, up); amt += 256 >> hi; end
                    if (mag == 3 || mag == 1) begin mv(hi + 1, up); amt += 256 >> (hi + 1); end
                    m_acc += up ? amt : -amt;
                end else if (m_cyc <= 7) begin
                    if (m_cyc == 3) mv(4, fine_in);
                    else if (fine_in) mp[m_cyc - 4] = 0;
                    else mn[m_cyc - 4] = 0;
                    m_acc += fine_in ? (256 >> (m_cyc + 1)) : -(256 >> (m_cyc + 1));
                end else begin
                    if (!fine_in) m_acc -= 1;
                    m_code = m_acc; m_done = 1; m_busy = 0;
                end
                m_cyc++;
            end
        end
    end

    function automatic int pack5(input int v[5]);
        int r = 0;
        for (int k = 0; k < 5; k++) r |= (v[k] & 1) << k;
        return r;
    endfunction

    function automatic int pack4(input int v[4]);
        int r = 0;
        for (int k = 0; k < 4; k++) r |= (v[k] & 1) << k;
        return r;
    endfunction

    always @(negedge clk) begin
        if (started) begin
            if (done) dones++;
            if (rst) begin
                chk("R1 split_p_a", int'(split_p_a), pack5(spa));
                chk("R1 split_p_b", int'(split_p_b), pack5(spb));
                chk("R1 mono", int'({mono_p, mono_n}), (pack4(mp) << 4) | pack4(mn));
                chk("R1 code", int'(code), 0);
                chk("R1 done", int'(done), 0);
            end else begin
                chk("R5/R6/R10 split_p_a", int'(split_p_a), pack5(spa));
                chk("R5/R6/R10 split_p_b", int'(split_p_b), pack5(spb));
                chk("R5/R6/R10 split_n_a", int'(split_n_a), pack5(sna));
                chk("R5/R6/R10 split_n_b", int'(split_n_b), pack5(snb));
                chk("R8 mono_p", int'(mono_p), pack4(mp));
                chk("R8 mono_n", int'(mono_n), pack4(mn));
                chk("R9 code", int'(code), m_code);
                chk("R9 done", int'(done), m_done);
            end
        end
    end

    task automatic run_conv(input logic [5:0] c1, input logic [5:0] c2, input logic [5:0] fb,
                            input int hold, input int mid_start);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            coarse_in = (i == 1) ? c1 : (i == 2) ? c2 : ~c1;
            fine_in   = (i >= 3) ? fb[i-3] : 1'b1;
            cmp_valid = 1'b1;
            if (mid_start != 0 && i == 4) start = 1'b1;
            repeat (hold) @(negedge clk);
            start = 1'b0;
            cmp_valid = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R3: strobes while idle change nothing
        cmp_valid = 1'b1; coarse_in = 6'b111111; @(negedge clk);
        cmp_valid = 1'b0; @(negedge clk);
        chk("R3 idle strobe split", int'(split_p_a), 31);
        chk("R3 idle strobe mono", int'(mono_n), 15);

        run_conv(6'b111111, 6'b000000, 6'b101010, 1, 0);
        chk("R4 code top A", int'(code), m_code);
        run_conv(6'b000000, 6'b111111, 6'b010101, 1, 0);
        chk("R4 code bottom A", int'(code), m_code);
        run_conv(6'b000111, 6'b001111, 6'b111111, 1, 0);
        chk("R4 code D then C", int'(code), m_code);
        run_conv(6'b101010, 6'b110100, 6'b001100, 1, 0);
        chk("R4 code non-monotonic", int'(code), m_code);
        run_conv(6'b011111, 6'b011111, 6'b000000, 1, 0);
        chk("R7 code upper B remap", int'(code), m_code);
        run_conv(6'b000001, 6'b100000, 6'b110011, 1, 0);
        chk("R7 code lower B remap", int'(code), m_code);
        run_conv(6'b000011, 6'b000111, 6'b011010, 3, 0);
        chk("R3 code held strobe", int'(code), m_code);
        d0 = dones;
        run_conv(6'b111110, 6'b001110, 6'b100101, 1, 1);
        chk("R2 code start ignored", int'(code), m_code);
        chk("R2 single done", dones - d0, 1);
        run_conv(6'b110000, 6'b111011, 6'b111000, 2, 0);
        chk("R9 code mixed", int'(code), m_code);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule